// File: doc/BRIEF.md
# Repeat-Mode DMA Address and Count Unit

This unit generates the addresses for one DMA channel that runs in repeat mode. It holds a 24-bit memory-side address and a 16-bit fixed-side address. The upper byte of the fixed-side address is always all ones. Each completed transfer moves the memory-side address up or down by one byte or one word. An 8-bit live counter decrements at the same time.

When the last transfer of a block completes, the live counter reloads from a holding register. In that same cycle the memory-side address is moved back by the block length times the step, so the next block starts at the same place. The channel never stops by itself and raises no completion interrupt. Software halts it by dropping the enable. Raising the enable again resumes from the next transfer, because the address and count are left as they were.

A direction control decides which side is the source and which is the destination. A one-cycle wrap pulse marks every reload.

Top module: `rpt_dma_addr_unit`

## Requirements
- R1: After reset the memory-side address, the fixed-side low half, the live count, the reload value and `wrap_pulse` are all zero.
- R2: Each accepted transfer changes the memory-side address by the step, modulo 2^24. The step is +1 when `size_word`=0 and `addr_down`=0, and +2 when `size_word`=1 and `addr_down`=0. Setting `addr_down`=1 negates the step.
- R3: The fixed-side address is 0xFF in bits 23:16 with the fixed-side register in bits 15:0.
- R4: When `mem_is_src`=1, `src_addr` is the memory-side address and `dst_addr` is the fixed-side address. When `mem_is_src`=0 the two are swapped.
- R5: Register writes use `wr_sel` as follows: 0 loads the memory-side address from `wr_data[23:0]`, 1 loads the fixed-side half from `wr_data[15:0]`, 2 loads the live count from `wr_data[7:0]`, and 3 loads the reload value from `wr_data[7:0]`.
- R6: With live count and reload both set to N, the N-th accepted transfer returns the memory-side address to its block start and sets the live count back to N. This holds for every step.
- R7: A reload value of 0 means blocks of 256 transfers. The rewind distance is then 256 times the step, taken modulo 2^24.
- R8: `wrap_pulse` is high for exactly the one cycle that follows the transfer ending a block. It is low in every other cycle.
- R9: A `xfer_done` strobe while `chan_en`=0 changes neither the address nor the count.
- R10: A strobe in the same cycle as a register write is dropped. Only the write takes effect.
- R11: Dropping `chan_en` and raising it again resumes within the same block. The channel keeps cycling through blocks without stopping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 memory address, 1 fixed half, 2 live count, 3 reload) |
| wr_data | input | 24 | Write data |
| chan_en | input | 1 | Channel enable |
| size_word | input | 1 | 1 = word (step 2), 0 = byte (step 1) |
| addr_down | input | 1 | 1 = memory address decrements |
| mem_is_src | input | 1 | 1 = memory side is the source |
| xfer_done | input | 1 | One transfer completed this cycle |
| src_addr | output | 24 | Source address |
| dst_addr | output | 24 | Destination address |
| wrap_pulse | output | 1 | One-cycle marker of a block reload |

## Verification
The assertions assume that `size_word` and `addr_down` stay steady throughout a block. They also assume that software writes the live count and the reload value with the same N before enabling the channel, so the arithmetic rewind lands on the block start. The stimulus reprograms all four registers while `chan_en` is low, and only then sweeps the size, direction and block lengths 1, 2, 3, 7 and 256. It also places start addresses so that the blocks cross the 2^24 boundary in both directions.

// File: rtl/rdma_pkg.sv
package rdma_pkg;
   typedef enum logic [1:0] {
      SEL_MEM    = 2'd0,
      SEL_FIX    = 2'd1,
      SEL_LIVE   = 2'd2,
      SEL_RELOAD = 2'd3
   } rdma_sel_e;
endpackage

// File: rtl/rdma_step_calc.sv
module rdma_step_calc #(
   parameter int ADDR_W       = 24,
   parameter int CNT_W        = 8,
   parameter bit SHIFT_REWIND = 1'b1
) (
   input  logic              size_word,
   input  logic              addr_down,
   input  logic [CNT_W-1:0]  reload,
   output logic [ADDR_W-1:0] delta,
   output logic [ADDR_W-1:0] rewind
);
   localparam int SPAN_W = CNT_W + 1;

   if (ADDR_W <= SPAN_W + 1) begin : g_bad_width
      $error("ADDR_W must exceed CNT_W + 2");
   end

   logic [SPAN_W-1:0] span;
   logic [ADDR_W-1:0] mag;
   logic [ADDR_W-1:0] rew_mag;

   // a zero reload stands for the full 2^CNT_W transfers
   assign span = (reload == '0) ? SPAN_W'(1) << CNT_W : {1'b0, reload};
   assign mag  = size_word ? ADDR_W'(2) : ADDR_W'(1);

   if (SHIFT_REWIND) begin : g_shift
      assign rew_mag = ADDR_W'(span) << size_word;
   end else begin : g_mult
      assign rew_mag = ADDR_W'(span) * mag;
   end

   assign delta  = addr_down ? (~mag + ADDR_W'(1))     : mag;
   assign rewind = addr_down ? (~rew_mag + ADDR_W'(1)) : rew_mag;
endmodule

// File: rtl/rdma_count.sv
module rdma_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_live,
   input  logic             wr_reload,
   input  logic [CNT_W-1:0] wr_val,
   input  logic             adv,
   output logic [CNT_W-1:0] reload,
   output logic             blk_end
);
   if (CNT_W < 2) begin : g_bad_cnt
      $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] live;

   assign blk_end = adv && (live == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         live   <= '0;
         reload <= '0;
      end else begin
         if (wr_reload) reload <= wr_val;
         if (wr_live)        live <= wr_val;
         else if (blk_end)   live <= reload;
         else if (adv)       live <= live - CNT_W'(1);
      end
   end

   // R6
   reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_end && !wr_live) |=> (live == $past(reload)));

   // R2
   count_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !blk_end && !wr_live) |=> (live == $past(live) - CNT_W'(1)));

   // R9
   count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv && !wr_live) |=> $stable(live));
endmodule

// File: rtl/rdma_maddr.sv
module rdma_maddr #(
   parameter int ADDR_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ADDR_W-1:0] wr_val,
   input  logic              adv,
   input  logic              blk_end,
   input  logic [ADDR_W-1:0] delta,
   input  logic [ADDR_W-1:0] rewind,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] stepped;

   assign stepped = addr + delta;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr <= '0;
      else if (wr)      addr <= wr_val;
      else if (blk_end) addr <= stepped - rewind;
      else if (adv)     addr <= stepped;
   end

   // R9
   addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr && !adv) |=> $stable(addr));

   // R2
   addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && !blk_end && !wr) |=> (addr == $past(addr) + $past(delta)));
endmodule

// File: rtl/rpt_dma_addr_unit.sv
module rpt_dma_addr_unit #(
   parameter int ADDR_W       = 24,
   parameter int FIX_W        = 16,
   parameter int CNT_W        = 8,
   parameter bit SHIFT_REWIND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic              chan_en,
   input  logic              size_word,
   input  logic              addr_down,
   input  logic              mem_is_src,
   input  logic              xfer_done,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic              wrap_pulse
);
   import rdma_pkg::*;

   localparam int HI_W = ADDR_W - FIX_W;

   if (FIX_W >= ADDR_W || CNT_W >= FIX_W) begin : g_bad_cfg
      $error("need CNT_W < FIX_W < ADDR_W");
   end

   rdma_sel_e         sel;
   logic              adv;
   logic              blk_end;
   logic [CNT_W-1:0]  reload;
   logic [ADDR_W-1:0] delta;
   logic [ADDR_W-1:0] rewind;
   logic [ADDR_W-1:0] mem_addr;
   logic [FIX_W-1:0]  fix_lo;
   logic [ADDR_W-1:0] fix_addr;

   assign sel      = rdma_sel_e'(wr_sel);
   assign adv      = chan_en && xfer_done && !wr_en;
   assign fix_addr = {{HI_W{1'b1}}, fix_lo};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fix_lo     <= '0;
         wrap_pulse <= 1'b0;
      end else begin
         if (wr_en && sel == SEL_FIX) fix_lo <= wr_data[FIX_W-1:0];
         wrap_pulse <= blk_end;
      end
   end

   rdma_step_calc #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .SHIFT_REWIND(SHIFT_REWIND)) u_step (
      .size_word (size_word),
      .addr_down (addr_down),
      .reload    (reload),
      .delta     (delta),
      .rewind    (rewind)
   );

   rdma_count #(.CNT_W(CNT_W)) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_live   (wr_en && sel == SEL_LIVE),
      .wr_reload (wr_en && sel == SEL_RELOAD),
      .wr_val    (wr_data[CNT_W-1:0]),
      .adv       (adv),
      .reload    (reload),
      .blk_end   (blk_end)
   );

   rdma_maddr #(.ADDR_W(ADDR_W)) u_maddr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_en && sel == SEL_MEM),
      .wr_val  (wr_data),
      .adv     (adv),
      .blk_end (blk_end),
      .delta   (delta),
      .rewind  (rewind),
      .addr    (mem_addr)
   );

   assign src_addr = mem_is_src ? mem_addr : fix_addr;
   assign dst_addr = mem_is_src ? fix_addr : mem_addr;

   // R3
   fix_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_is_src ? dst_addr[ADDR_W-1:FIX_W] : src_addr[ADDR_W-1:FIX_W]) == {HI_W{1'b1}});

   // R8
   wrap_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_pulse |-> $past(chan_en && xfer_done && !wr_en));

   // R10
   wr_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && xfer_done) |=> !wrap_pulse);
endmodule

// File: tb/tb_rpt_dma_addr_unit.sv
module tb_rpt_dma_addr_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [23:0] wr_data = '0;
   logic        chan_en = 1'b0;
   logic        size_word = 1'b0;
   logic        addr_down = 1'b0;
   logic        mem_is_src = 1'b1;
   logic        xfer_done = 1'b0;
   logic [23:0] src_addr;
   logic [23:0] dst_addr;
   logic        wrap_pulse;

   int n_vec = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   rpt_dma_addr_unit dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .chan_en(chan_en), .size_word(size_word), .addr_down(addr_down),
      .mem_is_src(mem_is_src), .xfer_done(xfer_done),
      .src_addr(src_addr), .dst_addr(dst_addr), .wrap_pulse(wrap_pulse)
   );

   task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] s, input logic [23:0] d, input logic strobe);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = s; wr_data = d; xfer_done = strobe;
      @(negedge clk);
      wr_en = 1'b0; xfer_done = 1'b0;
   endtask

   task automatic xfer();
      @(negedge clk);
      xfer_done = 1'b1;
      @(negedge clk);
      xfer_done = 1'b0;
   endtask

   task automatic program_blk(input logic [23:0] start, input logic [7:0] n);
      chan_en = 1'b0;
      wr(2'd0, start, 1'b0);
      wr(2'd2, {16'h0, n}, 1'b0);
      wr(2'd3, {16'h0, n}, 1'b0);
      chan_en = 1'b1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin : stim
      logic [7:0] lens [5];
      lens[0] = 8'd1; lens[1] = 8'd2; lens[2] = 8'd3; lens[3] = 8'd7; lens[4] = 8'd0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state seen at the ports
      chk("R1 mem", src_addr, 24'h000000);
      chk("R1 fix", dst_addr, 24'hFF0000);
      chk("R1 wrap", {23'h0, wrap_pulse}, 24'h0);

      // R3 and R5: fixed-side write
      wr(2'd1, 24'hAB1234, 1'b0);
      chk("R3", dst_addr, 24'hFF1234);
      wr(2'd0, 24'h456789, 1'b0);
      chk("R5 mem write", src_addr, 24'h456789);
      // R4: swapped direction
      mem_is_src = 1'b0;
      @(negedge clk);
      chk("R4 src", src_addr, 24'hFF1234);
      chk("R4 dst", dst_addr, 24'h456789);
      mem_is_src = 1'b1;

      // R2 R6 R7 R8 R11: sweep size, direction and block length
      for (int cfg = 0; cfg < 4; cfg++) begin
         for (int li = 0; li < 5; li++) begin
            int          nblk;
            int          left;
            logic [23:0] start;
            logic [23:0] d;
            logic [23:0] exp_mar;
            size_word = cfg[0];
            addr_down = cfg[1];
            nblk  = (lens[li] == 8'd0) ? 256 : int'(lens[li]);
            d     = addr_down ? (size_word ? 24'hFFFFFE : 24'hFFFFFF)
                              : (size_word ? 24'h000002 : 24'h000001);
            start = addr_down ? 24'h000005 : 24'hFFFFFA;
            program_blk(start, lens[li]);
            exp_mar = start;
            left = nblk;
            for (int t = 0; t < 2 * nblk + 1; t++) begin
               bit exp_wrap;
               xfer();
               left--;
               if (left == 0) begin
                  exp_mar = start; left = nblk; exp_wrap = 1'b1;
               end else begin
                  exp_mar = exp_mar + d; exp_wrap = 1'b0;
               end
               if (nblk == 256) chk("R7 addr", src_addr, exp_mar);
               else if (exp_wrap) chk("R6 restore", src_addr, exp_mar);
               else chk("R2 step", src_addr, exp_mar);
               chk(exp_wrap ? "R8 pulse" : "R11 no pulse", {23'h0, wrap_pulse}, {23'h0, exp_wrap});
            end
            @(negedge clk);
            chk("R8 single cycle", {23'h0, wrap_pulse}, 24'h0);
         end
      end

      // R9 and R11: ignored strobes while disabled, then resume
      size_word = 1'b0; addr_down = 1'b0;
      program_blk(24'h001000, 8'd4);
      xfer(); xfer();
      chk("R11 pre-pause", src_addr, 24'h001002);
      chan_en = 1'b0;
      xfer(); xfer(); xfer();
      chk("R9 addr held", src_addr, 24'h001002);
      chk("R9 no pulse", {23'h0, wrap_pulse}, 24'h0);
      chan_en = 1'b1;
      xfer();
      chk("R11 resume", src_addr, 24'h001003);
      chk("R11 no early wrap", {23'h0, wrap_pulse}, 24'h0);
      xfer();
      chk("R11 wrap after resume", src_addr, 24'h001000);
      chk("R9 count held", {23'h0, wrap_pulse}, 24'h000001);

      // R10: strobe colliding with a write is dropped
      wr(2'd0, 24'h002000, 1'b1);
      chk("R10 write wins", src_addr, 24'h002000);
      xfer(); xfer(); xfer();
      chk("R10 count untouched", {23'h0, wrap_pulse}, 24'h0);
      xfer();
      chk("R10 wrap at 4th", {23'h0, wrap_pulse}, 24'h000001);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule